// File: doc/BRIEF.md
# Three-channel prescaled interval timer

A small memory-mapped timer with three independent 16-bit up-counters fed from the same input clock. Each channel can free-run and roll over at 0xFFFF, or act as an interval timer that counts from zero up to a programmed limit, returns to zero and flags an event. A power-of-two prescaler per channel slows the count rate. Each channel drives one interrupt line, which is the OR of its pending status bits gated by their enables.

Software reaches the registers over a simple single-cycle bus: a request with a write flag, a byte address and a data word. Read data is returned combinationally in the request cycle. Side effects such as clearing status take place at the clock edge that ends the request. Each register kind has its own base offset, and the three channels sit in consecutive words above that base.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every channel reads: clock control 0, counter control 0x0001 (stopped, free-running), count 0, interval 0xFFFF, status 0, enable 0, and every interrupt line is low.
- R2: Register bases are clock control 0x00, counter control 0x0C, count 0x18, interval 0x24, status 0x54 and enable 0x60. Channel n adds 4*n. Any other address, including a misaligned one, reads 0 and ignores writes.
- R3: In free-running mode (counter control bit 1 = 0) the count rises by one per count step. It wraps from 0xFFFF to 0, and the wrap sets status bit 4. The count register returns the current count in the cycle it is read.
- R4: Clock control bit 0 enables the prescaler, and bits [4:1] hold P. With the prescaler on, a running counter steps once every 2^(P+1) clocks, so after j clocks from a reset write the count is floor(j/2^(P+1)). With it off, the counter steps every clock.
- R5: Counter control bit 0 = 1 stops the counter and holds its value. Writing 0 lets it run again.
- R6: Writing 1 to counter control bit 4 zeroes the count and the prescale phase in that cycle. The bit always reads 0.
- R7: In interval mode (counter control bit 1 = 1) with limit V, the count goes 0..V. On the next step it returns to 0 and sets status bit 0.
- R8: A status read returns the pending bits and clears them. An event that arrives in the same cycle as the read stays pending.
- R9: A channel's interrupt line is high exactly when some status bit and the enable bit in the same position (0 or 4) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock shared by all channels |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while a read request is present |
| irq_o | output | 3 | One interrupt line per channel |

## Verification
The prescaler is swept over every exponent from 0 to 4, and the count is sampled one clock before and one clock at a step boundary. This separates a divide of 2^(P+1) from 2^P and exposes any off-by-one in the prescale phase. Interval mode is tried with limits 0, 1, 2, 3, 7 and 100 on rotating channels. These patterns show the exact return-to-zero cycle and catch any crosstalk between channels. A limit of 0 puts a new event in the same cycle as the status read, so it checks that the event is kept. A full 65536-clock free run checks the wrap and the overflow flag. Distinct interval values per channel, together with accesses to unmapped and misaligned addresses, check the interleaved address decode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned CH_W      = 4;
  localparam int unsigned NUM_KINDS = 6;

  // field positions
  localparam int unsigned CLK_EN    = 0;
  localparam int unsigned CTL_STOP  = 0;
  localparam int unsigned CTL_IMODE = 1;
  localparam int unsigned CTL_ZERO  = 4;
  localparam int unsigned EV_IVL    = 0;
  localparam int unsigned EV_OVF    = 4;

  typedef enum logic [2:0] {
    REG_NONE, REG_CLK, REG_CTL, REG_CNT, REG_IVL, REG_STS, REG_IEN
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e       kind;
    logic [CH_W-1:0] ch;
  } reg_sel_t;

  function automatic logic [ADDR_W-1:0] kind_base(input int k);
    case (k)
      0:       return 8'h00;
      1:       return 8'h0C;
      2:       return 8'h18;
      3:       return 8'h24;
      4:       return 8'h54;
      default: return 8'h60;
    endcase
  endfunction

  function automatic reg_sel_t decode(input logic [ADDR_W-1:0] addr, input int unsigned nch);
    reg_sel_t s;
    logic [ADDR_W-1:0] d;
    s.kind = REG_NONE;
    s.ch   = '0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      d = addr - kind_base(k);
      if (addr >= kind_base(k) && d[1:0] == 2'b00 && 32'(d[ADDR_W-1:2]) < nch) begin
        s.kind = reg_kind_e'(3'(k + 1));
        s.ch   = CH_W'(d[ADDR_W-1:2]);
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [PW-1:0] exp_i,
  output logic          tick_o
);
  localparam int unsigned PRE_W = 1 << PW;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // divide by 2^(exp+1): low exp+1 bits all ones
  always_comb mask = ~({PRE_W{1'b1}} << ({1'b0, exp_i} + 1'b1));
  assign tick_o = !en_i || ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else if (run_i) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] wdata_i,
  input  logic          we_clk_i,
  input  logic          we_ctl_i,
  input  logic          we_ivl_i,
  input  logic          we_ien_i,
  input  logic          rd_sts_i,
  output logic [PW:0]   clk_cfg_o,
  output logic [1:0]    ctl_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] ival_o,
  output logic [1:0]    sts_o,
  output logic [1:0]    ien_o,
  output logic          irq_o,
  output logic          run_o,
  output logic          tick_o,
  output logic          clr_o
);
  logic          pre_en_q, stop_q, imode_q;
  logic [PW-1:0] pre_exp_q;
  logic [CW-1:0] cnt_q, ival_q;
  logic [1:0]    sts_q, ien_q, evt;
  logic          clr_cnt, step, hit_ivl, hit_ovf;

  assign clr_cnt = we_ctl_i && wdata_i[CTL_ZERO];
  assign run_o   = !stop_q;

  tmr_prescaler #(.PW(PW)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_o),
    .clr_i  (clr_cnt || we_clk_i),
    .en_i   (pre_en_q),
    .exp_i  (pre_exp_q),
    .tick_o (tick_o)
  );

  assign step    = run_o && tick_o;
  assign hit_ivl = step && imode_q && (cnt_q == ival_q);
  assign hit_ovf = step && !imode_q && (&cnt_q);
  // a zeroing write in the same cycle suppresses the event
  assign evt     = {hit_ovf, hit_ivl} & {2{!clr_cnt}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_en_q  <= 1'b0;
      pre_exp_q <= '0;
      stop_q    <= 1'b1;
      imode_q   <= 1'b0;
      ival_q    <= '1;
      ien_q     <= '0;
    end else begin
      if (we_clk_i) begin
        pre_en_q  <= wdata_i[CLK_EN];
        pre_exp_q <= wdata_i[PW:1];
      end
      if (we_ctl_i) begin
        stop_q  <= wdata_i[CTL_STOP];
        imode_q <= wdata_i[CTL_IMODE];
      end
      if (we_ivl_i) ival_q <= wdata_i;
      if (we_ien_i) ien_q  <= {wdata_i[EV_OVF], wdata_i[EV_IVL]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_cnt) cnt_q <= '0;
    else if (hit_ivl) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (rd_sts_i ? 2'b00 : sts_q) | evt;
  end

  assign clk_cfg_o = {pre_exp_q, pre_en_q};
  assign ctl_o     = {imode_q, stop_q};
  assign cnt_o     = cnt_q;
  assign ival_o    = ival_q;
  assign sts_o     = sts_q;
  assign ien_o     = ien_q;
  assign irq_o     = |(sts_q & ien_q);
  assign clr_o     = clr_cnt;
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned CW  = 16,
  parameter int unsigned PW  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW-1:0]     rdata_o,
  output logic [NCH-1:0]    irq_o
);
  reg_sel_t sel;
  assign sel = decode(addr_i, NCH);

  logic [NCH-1:0][PW:0]   clk_cfg_a;
  logic [NCH-1:0][1:0]    ctl_a, sts_a, ien_a;
  logic [NCH-1:0][CW-1:0] cnt_a, ival_a;
  logic [NCH-1:0]         run_a, tick_a, clr_a, rd_sts_a;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit         = req_i && (sel.ch == CH_W'(c));
    assign rd_sts_a[c] = hit && !we_i && sel.kind == REG_STS;

    tmr_channel #(.CW(CW), .PW(PW)) i_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wdata_i   (wdata_i),
      .we_clk_i  (hit && we_i && sel.kind == REG_CLK),
      .we_ctl_i  (hit && we_i && sel.kind == REG_CTL),
      .we_ivl_i  (hit && we_i && sel.kind == REG_IVL),
      .we_ien_i  (hit && we_i && sel.kind == REG_IEN),
      .rd_sts_i  (rd_sts_a[c]),
      .clk_cfg_o (clk_cfg_a[c]),
      .ctl_o     (ctl_a[c]),
      .cnt_o     (cnt_a[c]),
      .ival_o    (ival_a[c]),
      .sts_o     (sts_a[c]),
      .ien_o     (ien_a[c]),
      .irq_o     (irq_o[c]),
      .run_o     (run_a[c]),
      .tick_o    (tick_a[c]),
      .clr_o     (clr_a[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      for (int c = 0; c < NCH; c++) begin
        if (sel.ch == CH_W'(c)) begin
          case (sel.kind)
            REG_CLK: rdata_o[PW:0] = clk_cfg_a[c];
            REG_CTL: rdata_o[1:0]  = ctl_a[c];
            REG_CNT: rdata_o       = cnt_a[c];
            REG_IVL: rdata_o       = ival_a[c];
            REG_STS: begin
              rdata_o[EV_IVL] = sts_a[c][0];
              rdata_o[EV_OVF] = sts_a[c][1];
            end
            REG_IEN: begin
              rdata_o[EV_IVL] = ien_a[c][0];
              rdata_o[EV_OVF] = ien_a[c][1];
            end
            default: rdata_o = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tri_interval_timer_chk.sv
module tri_interval_timer_chk #(
  parameter int unsigned NCH = 3,
  parameter int unsigned CW  = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NCH-1:0]         irq_i,
  input logic [NCH-1:0]         run_i,
  input logic [NCH-1:0]         tick_i,
  input logic [NCH-1:0]         clr_i,
  input logic [NCH-1:0]         rd_sts_i,
  input logic [NCH-1:0][1:0]    ctl_i,
  input logic [NCH-1:0][1:0]    sts_i,
  input logic [NCH-1:0][1:0]    ien_i,
  input logic [NCH-1:0][CW-1:0] cnt_i,
  input logic [NCH-1:0][CW-1:0] ival_i
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ien_i[c] == 2'b00) |-> !irq_i[c]);
    p_no_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_i[c] == 2'b00) |-> !irq_i[c]);
    p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[c] && tick_i[c] && !ctl_i[c][1] && (&cnt_i[c]) && !clr_i[c])
      |=> (cnt_i[c] == '0) && sts_i[c][1]);
    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i[c] && !clr_i[c]) |=> (cnt_i[c] == $past(cnt_i[c])));
    p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[c] |=> (cnt_i[c] == '0));
    p_limit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[c] && tick_i[c] && ctl_i[c][1] && (cnt_i[c] == ival_i[c]) && !clr_i[c])
      |=> (cnt_i[c] == '0) && sts_i[c][0]);
    p_rd_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_sts_i[c] && !(run_i[c] && tick_i[c])) |=> (sts_i[c] == 2'b00));
    p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_sts_i[c] && sts_i[c][0]) |=> sts_i[c][0]);
  end
endmodule

bind tri_interval_timer tri_interval_timer_chk #(.NCH(NCH), .CW(CW)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_o),
  .run_i    (run_a),
  .tick_i   (tick_a),
  .clr_i    (clr_a),
  .rd_sts_i (rd_sts_a),
  .ctl_i    (ctl_a),
  .sts_i    (sts_a),
  .ien_i    (ien_a),
  .cnt_i    (cnt_a),
  .ival_i   (ival_a)
);

// File: tb/test_tri_interval_timer.sv
`timescale 1ns/1ps
module test_tri_interval_timer;
  localparam int NCH = 3;
  localparam logic [7:0] A_CLK = 8'h00, A_CTL = 8'h0C, A_CNT = 8'h18,
                         A_IVL = 8'h24, A_STS = 8'h54, A_IEN = 8'h60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [NCH-1:0] irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tri_interval_timer i_tri_interval_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] ra(input logic [7:0] base, input int ch);
    return base + 8'(4 * ch);
  endfunction

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state
    check("R1 irq", 16'(irq), 16'h0);
    for (int c = 0; c < NCH; c++) begin
      rd_chk("R1 clk", ra(A_CLK, c), 16'h0000);
      rd_chk("R1 ctl", ra(A_CTL, c), 16'h0001);
      rd_chk("R1 cnt", ra(A_CNT, c), 16'h0000);
      rd_chk("R1 ivl", ra(A_IVL, c), 16'hFFFF);
      rd_chk("R1 sts", ra(A_STS, c), 16'h0000);
      rd_chk("R1 ien", ra(A_IEN, c), 16'h0000);
    end

    // R2 interleaved map, unmapped and misaligned addresses
    for (int c = 0; c < NCH; c++) wr(ra(A_IVL, c), 16'h1111 * 16'(c + 1));
    wr(8'h30, 16'hABCD);
    wr(8'h26, 16'h5A5A);
    for (int c = 0; c < NCH; c++) rd_chk("R2 ivl", ra(A_IVL, c), 16'h1111 * 16'(c + 1));
    rd_chk("R2 unmapped", 8'h30, 16'h0);
    rd_chk("R2 misaligned", 8'h26, 16'h0);
    for (int c = 0; c < NCH; c++) wr(ra(A_IVL, c), 16'hFFFF);

    // R5 / R6 on channel 1
    wr(ra(A_CTL, 1), 16'h0010);
    idle(9);
    rd_chk("R3 count", ra(A_CNT, 1), 16'd9);
    wr(ra(A_CTL, 1), 16'h0001);
    rd_chk("R5 stop", ra(A_CNT, 1), 16'd11);
    idle(20);
    rd_chk("R5 hold", ra(A_CNT, 1), 16'd11);
    wr(ra(A_CTL, 1), 16'h0011);
    rd_chk("R6 zero", ra(A_CNT, 1), 16'd0);
    rd_chk("R6 bit reads 0", ra(A_CTL, 1), 16'h0001);

    // R4 prescale sweep on channel 2
    for (int p = 0; p <= 4; p++) begin
      int dv;
      dv = 1 << (p + 1);
      wr(ra(A_CLK, 2), 16'((p << 1) | 1));
      rd_chk("R4 clk readback", ra(A_CLK, 2), 16'((p << 1) | 1));
      wr(ra(A_CTL, 2), 16'h0010);
      idle(3 * dv - 1);
      rd_chk("R4 before step", ra(A_CNT, 2), 16'd2);
      rd_chk("R4 at step", ra(A_CNT, 2), 16'd3);
      wr(ra(A_CTL, 2), 16'h0011);
    end
    wr(ra(A_CLK, 2), 16'h0000);

    // R7 / R8 / R9 interval sweep
    for (int i = 0; i < 6; i++) begin
      int v, ch;
      logic [15:0] ien;
      logic ien0;
      case (i)
        0: v = 0; 1: v = 1; 2: v = 2; 3: v = 3; 4: v = 7; default: v = 100;
      endcase
      ch = i % NCH;
      ien = (i == 5) ? 16'h0010 : 16'h0001;
      ien0 = ien[0];
      wr(ra(A_IVL, ch), 16'(v));
      wr(ra(A_IEN, ch), ien);
      wr(ra(A_CTL, ch), 16'h0012);
      check("R9 no irq before event", 16'(irq[ch]), 16'h0);
      idle(v);
      rd_chk("R7 reaches limit", ra(A_CNT, ch), 16'(v));
      check("R9 irq on event", 16'(irq[ch]), 16'(ien0));
      rd_chk("R7 status bit0", ra(A_STS, ch), 16'h0001);
      check("R8 irq after read", 16'(irq[ch]), (v == 0) ? 16'(ien0) : 16'h0);
      if (v >= 2) rd_chk("R7 restarts", ra(A_CNT, ch), 16'd1);
      wr(ra(A_CTL, ch), 16'h0013);
      rd(ra(A_STS, ch), d);
      rd_chk("R8 cleared", ra(A_STS, ch), 16'h0000);
      check("R9 other lines", 16'(irq), 16'h0);
    end

    // R3 full free-run wrap on channel 0
    wr(ra(A_IEN, 0), 16'h0010);
    wr(ra(A_CTL, 0), 16'h0010);
    idle(65535);
    rd_chk("R3 top", ra(A_CNT, 0), 16'hFFFF);
    check("R9 ovf irq", 16'(irq[0]), 16'h1);
    rd_chk("R3 ovf status", ra(A_STS, 0), 16'h0010);
    rd_chk("R3 wrapped", ra(A_CNT, 0), 16'd1);
    check("R8 ovf cleared", 16'(irq[0]), 16'h0);
    wr(ra(A_CTL, 0), 16'h0001);

    finish_run();
  end
endmodule